// File: doc/BRIEF.md
# AHB Pipeline-Aware Transfer Monitor

This block watches a single-layer AHB-Lite bus without driving any of its signals. It rebuilds every completed transfer into one record. An address phase is captured on a clock edge where the bus is ready and the transfer type is NONSEQ or SEQ. The captured address and control are held as the pending data phase. When a later cycle with HREADY high ends that data phase, the block presents a record for exactly one cycle.

The record pairs the held address with the data of the completing cycle. That data is the write data for writes and the read data for reads. The record also carries a flag for an error completion and the number of wait cycles that stretched the data phase. Scoreboards and trace logic downstream can use it without having to work out the bus pipeline themselves.

Top module: `ahb_xfer_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, `rec_valid` stays low. Reset also discards a data phase that was pending.
- R2: The record's address, direction, size, burst and transfer type come from the address phase accepted earlier, never from the live `haddr`.
- R3: An address phase is accepted only on a rising edge with `hready` high and `htrans` equal to NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) phases produce no record.
- R4: `rec_valid` is high for exactly one cycle per accepted transfer. That cycle is the `hready`-high cycle that ends its data phase.
- R5: A write record carries `hwdata` and a read record carries `hrdata`, both taken in the completing cycle. Read data present while `hready` is low never reaches a record.
- R6: While `hready` is low, the pending data phase is held unchanged. Address-phase values presented during those cycles are not captured.
- R7: `rec_err` is 1 when `hresp` is ERROR (1) in the completing cycle, which is the second cycle of the two-cycle error response. A completion with `hresp` OKAY (0) gives `rec_err` = 0, whatever waits came before it.
- R8: `rec_waits` counts the `hready`-low cycles of the data phase, and it saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| haddr | input | AW | Bus address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type |
| hwdata | input | DW | Write data |
| hrdata | input | DW | Read data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | 0 = OKAY, 1 = ERROR |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_addr | output | AW | Address of the completed transfer |
| rec_write | output | 1 | Direction of the completed transfer |
| rec_size | output | 3 | Size of the completed transfer |
| rec_burst | output | 3 | Burst type of the completed transfer |
| rec_trans | output | 2 | Transfer type (NONSEQ or SEQ) |
| rec_data | output | DW | Write or read data |
| rec_err | output | 1 | Error completion |
| rec_waits | output | WW | Wait cycles in the data phase (saturating) |

## Verification
The bench issues back-to-back transfers and checks that each record carries the previous address. A design that tagged data with the live address would report the next transfer's address. Read waits are given changing garbage on `hrdata`, so a design that sampled mid-wait would return a wrong data value or pulse too early. IDLE and BUSY phases, a two-cycle error that is held during a wait, a long stall that drives the wait counter past 255, and a reset applied with a data phase pending are all exercised. Each one exposes its own failure: phantom records, a missing error flag, a counter that wraps, or a stale record leaking out of reset.

// File: rtl/ahb_xfer_monitor.sv
module ahb_xfer_monitor #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 8
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [2:0]    hburst,
  input  logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp,
  output logic          rec_valid,
  output logic [AW-1:0] rec_addr,
  output logic          rec_write,
  output logic [2:0]    rec_size,
  output logic [2:0]    rec_burst,
  output logic [1:0]    rec_trans,
  output logic [DW-1:0] rec_data,
  output logic          rec_err,
  output logic [WW-1:0] rec_waits
);
  localparam logic [WW-1:0] WMAX = '1;

  logic          pend;
  logic [AW-1:0] p_addr;
  logic          p_write;
  logic [2:0]    p_size;
  logic [2:0]    p_burst;
  logic [1:0]    p_trans;
  logic [WW-1:0] waits;

  wire active = htrans[1];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      pend    <= 1'b0;
      p_addr  <= '0;
      p_write <= 1'b0;
      p_size  <= '0;
      p_burst <= '0;
      p_trans <= '0;
      waits   <= '0;
    end else if (hready) begin
      pend  <= active;
      waits <= '0;
      if (active) begin
        p_addr  <= haddr;
        p_write <= hwrite;
        p_size  <= hsize;
        p_burst <= hburst;
        p_trans <= htrans;
      end
    end else if (pend && waits != WMAX) begin
      waits <= waits + 1'b1;
    end
  end

  assign rec_valid = pend & hready;
  assign rec_addr  = p_addr;
  assign rec_write = p_write;
  assign rec_size  = p_size;
  assign rec_burst = p_burst;
  assign rec_trans = p_trans;
  assign rec_data  = p_write ? hwdata : hrdata;
  assign rec_err   = pend & hready & hresp;
  assign rec_waits = waits;
endmodule

module ahb_xfer_monitor_chk #(
  parameter int AW = 32,
  parameter int WW = 8
) (
  input logic          hclk,
  input logic          hresetn,
  input logic [AW-1:0] haddr,
  input logic          hready,
  input logic          hresp,
  input logic          rec_valid,
  input logic [AW-1:0] rec_addr,
  input logic          rec_err,
  input logic [WW-1:0] rec_waits
);
  a_r1_quiet_after_reset: assert property (@(posedge hclk)
    $rose(hresetn) |-> !rec_valid);

  a_r4_valid_needs_ready: assert property (@(posedge hclk) disable iff (!hresetn)
    rec_valid |-> hready);

  a_r2_prev_address: assert property (@(posedge hclk) disable iff (!hresetn)
    (rec_valid && $past(hready) && $past(hresetn)) |-> rec_addr == $past(haddr));

  a_r6_hold_in_wait: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |=> $stable(rec_addr));

  a_r7_err_two_cycle: assert property (@(posedge hclk) disable iff (!hresetn)
    (rec_err && $past(hresetn)) |-> $past(hresp && !hready));

  a_r8_waits_clear: assert property (@(posedge hclk) disable iff (!hresetn)
    rec_valid |=> rec_waits == '0);
endmodule

bind ahb_xfer_monitor ahb_xfer_monitor_chk #(.AW(AW), .WW(WW)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .hready(hready), .hresp(hresp),
  .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_err(rec_err), .rec_waits(rec_waits)
);

// File: tb/sim_ahb_xfer_monitor.sv
module sim_ahb_xfer_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WW = 8;

  typedef struct packed {
    logic [1:0]  trans;
    logic [31:0] addr;
    logic        wr;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic        rdy;
    logic        resp;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        ev;
    logic [31:0] eaddr;
    logic        ewr;
    logic [2:0]  esize;
    logic [2:0]  eburst;
    logic [1:0]  etrans;
    logic [31:0] edata;
    logic        eerr;
    logic [7:0]  ewait;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 32'h100, 1'b1, 3'd2, 3'd0, 1'b1, 1'b0, 32'h0,    32'h0,    1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b10, 32'h104, 1'b0, 3'd1, 3'd0, 1'b1, 1'b0, 32'hAAAA, 32'h1111, 1'b1, 32'h100, 1'b1, 3'd2, 3'd0, 2'b10, 32'hAAAA, 1'b0, 8'd0},
    '{2'b00, 32'h500, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0,    32'hDEAD, 1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b00, 32'h500, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0,    32'hBEEF, 1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b00, 32'h500, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 32'h0,    32'h1234, 1'b1, 32'h104, 1'b0, 3'd1, 3'd0, 2'b10, 32'h1234, 1'b0, 8'd2},
    '{2'b01, 32'h600, 1'b1, 3'd2, 3'd1, 1'b1, 1'b0, 32'h0,    32'h0,    1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b11, 32'h200, 1'b1, 3'd2, 3'd1, 1'b1, 1'b0, 32'h0,    32'h0,    1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b10, 32'h300, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 32'hBAD,  32'h0,    1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0},
    '{2'b10, 32'h300, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 32'h5555, 32'h0,    1'b1, 32'h200, 1'b1, 3'd2, 3'd1, 2'b11, 32'h5555, 1'b1, 8'd1},
    '{2'b00, 32'h0,   1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 32'h0,    32'h7777, 1'b1, 32'h300, 1'b0, 3'd0, 3'd0, 2'b10, 32'h7777, 1'b0, 8'd0},
    '{2'b00, 32'h0,   1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 32'h0,    32'h8888, 1'b0, 32'h0,   1'b0, 3'd0, 3'd0, 2'b00, 32'h0,    1'b0, 8'd0}
  };

  logic          hclk = 1'b0;
  logic          hresetn = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic [2:0]    hsize = '0;
  logic [2:0]    hburst = '0;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] hrdata = '0;
  logic          hready = 1'b1;
  logic          hresp = 1'b0;
  logic          rec_valid;
  logic [AW-1:0] rec_addr;
  logic          rec_write;
  logic [2:0]    rec_size;
  logic [2:0]    rec_burst;
  logic [1:0]    rec_trans;
  logic [DW-1:0] rec_data;
  logic          rec_err;
  logic [WW-1:0] rec_waits;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  ahb_xfer_monitor #(.AW(AW), .DW(DW), .WW(WW)) u0 (
    .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .hresp(hresp), .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_write(rec_write),
    .rec_size(rec_size), .rec_burst(rec_burst), .rec_trans(rec_trans),
    .rec_data(rec_data), .rec_err(rec_err), .rec_waits(rec_waits)
  );

  always #(CLK_PERIOD/2) hclk = ~hclk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [31:0] a, input logic w,
                       input logic rdy, input logic rsp, input logic [31:0] wd,
                       input logic [31:0] rd);
    htrans = t; haddr = a; hwrite = w; hready = rdy; hresp = rsp; hwdata = wd; hrdata = rd;
  endtask

  task automatic next_cycle();
    @(posedge hclk);
    #1;
  endtask

  initial begin
    #1;
    @(negedge hclk);
    chk("R1 valid in reset", rec_valid, 0);
    next_cycle();
    hresetn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].trans, VEC[i].addr, VEC[i].wr, VEC[i].rdy, VEC[i].resp,
            VEC[i].wdata, VEC[i].rdata);
      hsize = VEC[i].size;
      hburst = VEC[i].burst;
      @(negedge hclk);
      chk($sformatf("R4 valid vec%0d", i), rec_valid, VEC[i].ev);
      if (VEC[i].ev) begin
        chk($sformatf("R2 addr vec%0d", i), rec_addr, VEC[i].eaddr);
        chk($sformatf("R2 write vec%0d", i), rec_write, VEC[i].ewr);
        chk($sformatf("R2 size vec%0d", i), rec_size, VEC[i].esize);
        chk($sformatf("R2 burst vec%0d", i), rec_burst, VEC[i].eburst);
        chk($sformatf("R3 trans vec%0d", i), rec_trans, VEC[i].etrans);
        chk($sformatf("R5 data vec%0d", i), rec_data, VEC[i].edata);
        chk($sformatf("R7 err vec%0d", i), rec_err, VEC[i].eerr);
        chk($sformatf("R8 waits vec%0d", i), rec_waits, VEC[i].ewait);
      end
      next_cycle();
    end

    // R8: long stall saturates the wait count
    drive(2'b10, 32'h400, 1'b0, 1'b1, 1'b0, 0, 0);
    next_cycle();
    for (int k = 0; k < 300; k++) begin
      drive(2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 0, 32'hF0F0 + k);
      @(negedge hclk);
      if (k == 299) chk("R5 no record mid-wait", rec_valid, 0);
      next_cycle();
    end
    drive(2'b00, 32'h0, 1'b0, 1'b1, 1'b0, 0, 32'h99);
    @(negedge hclk);
    chk("R4 valid after stall", rec_valid, 1);
    chk("R8 waits saturate", rec_waits, 255);
    chk("R5 data after stall", rec_data, 32'h99);
    chk("R6 addr held over stall", rec_addr, 32'h400);
    next_cycle();

    // R1: reset with a pending data phase discards it
    drive(2'b10, 32'h700, 1'b1, 1'b1, 1'b0, 0, 0);
    next_cycle();
    hresetn = 1'b0;
    drive(2'b00, 32'h0, 1'b0, 1'b1, 1'b0, 32'h1, 0);
    @(negedge hclk);
    chk("R1 valid held low in reset", rec_valid, 0);
    next_cycle();
    hresetn = 1'b1;
    @(negedge hclk);
    chk("R1 no stale record after reset", rec_valid, 0);
    next_cycle();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge hclk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule